// File: doc/BRIEF.md
# Burst Address Offset Sequencer

This block generates the address of every beat in a short burst. When the caller pulses the load input, the block captures a full start address. Only the lowest bits of that address change during the burst. The upper bits stay at the captured value until the next load.

Each advance pulse moves the burst forward by one beat. Two step orders are available, chosen by a static mode input:
- **Interleaved order:** the offset is the start offset XOR the beat number.
- **Linear order:** the offset is the start offset plus the beat number, wrapping within the burst.

The block outputs the composed address and the current beat number. The caller decodes its own strobes into the load and advance pulses. The caller also owns the memory access.

Between advance pulses the address holds, which gives the caller wait states. After the last beat, a further advance wraps the burst back to its start offset.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and right after it, `addr_o` is all zeros and `beat_o` is zero.
- R2: A clock edge with `load_i` high captures `start_addr_i`. After that edge, `addr_o` equals `start_addr_i` and `beat_o` is 0.
- R3: `adv_i` has no effect on an edge where `load_i` is high. The result of that edge is the same as a load without advance.
- R4: With `interleave_i` = 1, the low `BEAT_W` bits of `addr_o` equal the captured start offset XOR `beat_o`. For `BEAT_W`=2, start 01 gives 01, 00, 11, 10.
- R5: With `interleave_i` = 0, the low `BEAT_W` bits of `addr_o` equal (captured start offset + `beat_o`) modulo 2^`BEAT_W`. For `BEAT_W`=2, start 11 gives 11, 00, 01, 10.
- R6: An edge with both `load_i` and `adv_i` low leaves `beat_o` unchanged. It also leaves `addr_o` unchanged as long as the mode input is steady.
- R7: An advance from the last beat (`beat_o` = 2^`BEAT_W`-1) returns `beat_o` to 0 and the offset to the captured start offset.
- R8: Bits `ADDR_W-1` down to `BEAT_W` of `addr_o` change only on a load edge. They equal the upper bits of the captured start address.
- R9: An edge with `adv_i` high and `load_i` low raises `beat_o` by exactly one, modulo 2^`BEAT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture a new start address; has priority over advance |
| adv_i | input | 1 | Step to the next beat |
| interleave_i | input | 1 | Static order select: 1 = XOR order, 0 = linear order |
| start_addr_i | input | ADDR_W | Start address sampled on a load edge |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | BEAT_W | Current beat number |

## Verification
The bench builds the block with `ADDR_W`=6 and `BEAT_W`=2. This leaves four upper bits and a four-beat burst.

That configuration makes an exhaustive sweep cheap. The sweep covers both orders, every start offset and two contrasting upper-bit patterns. Each burst runs five advances, so the wrap to the start is always exercised. Hold cycles are inserted between beats.

The small width also lets the bench compute each expected offset directly from the start offset and the beat count. This makes the simultaneous load-and-advance case, and a reload in the middle of a burst, easy to check by hand.

// File: rtl/burst_pkg.sv
package burst_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

endpackage

// File: rtl/burst_base_reg.sv
// Holds the start address captured by the most recent load.
module burst_base_reg #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] base_o
);

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (load_i) begin
         base_q <= addr_i;
      end
   end

   assign base_o = base_q;

endmodule

// File: rtl/burst_beat_cnt.sv
// Beat counter: cleared by load (load wins over advance), stepped by advance, wraps naturally.
module burst_beat_cnt #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   output logic [BEAT_W-1:0] beat_o
);

   localparam logic [BEAT_W-1:0] STEP = BEAT_W'(1);

   logic [BEAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
      end else if (adv_i) begin
         cnt_q <= cnt_q + STEP;
      end
   end

   assign beat_o = cnt_q;

endmodule

// File: rtl/burst_ofs_map.sv
// Maps (start offset, beat number) to the beat offset for the selected order.
module burst_ofs_map
   import burst_pkg::*;
#(
   parameter int BEAT_W = 2
) (
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] beat_i,
   input  burst_order_e      order_i,
   output logic [BEAT_W-1:0] ofs_o
);

   logic [BEAT_W-1:0] xor_ofs;
   logic [BEAT_W-1:0] lin_ofs;

   // Interleaved lanes: each offset bit flips independently.
   for (genvar g = 0; g < BEAT_W; g++) begin : g_lane
      assign xor_ofs[g] = start_i[g] ^ beat_i[g];
   end

   // Linear: modular add, carry beyond the burst field discarded.
   if (BEAT_W == 1) begin : g_lin_one
      assign lin_ofs = start_i ^ beat_i;
   end else begin : g_lin_add
      assign lin_ofs = start_i + beat_i;
   end

   always_comb begin
      unique case (order_i)
         ORD_INTERLEAVE: ofs_o = xor_ofs;
         default:        ofs_o = lin_ofs;
      endcase
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic              interleave_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BEAT_W-1:0] beat_o
);

   localparam int UPPER_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
      $error("burst_addr_seq: BEAT_W must be 1..8");
   end
   if (UPPER_W < 1) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BEAT_W");
   end

   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] ofs;
   burst_order_e      order;

   assign order = burst_order_e'(interleave_i);

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .addr_i (start_addr_i),
      .base_o (base)
   );

   burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .adv_i  (adv_i),
      .beat_o (beat)
   );

   burst_ofs_map #(.BEAT_W(BEAT_W)) u_map (
      .start_i (base[BEAT_W-1:0]),
      .beat_i  (beat),
      .order_i (order),
      .ofs_o   (ofs)
   );

   assign addr_o = {base[ADDR_W-1:BEAT_W], ofs};
   assign beat_o = beat;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic              adv_i,
   input logic              interleave_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [BEAT_W-1:0] beat_o
);

   logic [BEAT_W-1:0] ofs_w;
   logic [BEAT_W-1:0] mix_x;
   logic [BEAT_W-1:0] mix_l;

   assign ofs_w = addr_o[BEAT_W-1:0];
   assign mix_x = ofs_w ^ beat_o;
   assign mix_l = ofs_w - beat_o;

   assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (beat_o == '0) && (addr_o == $past(start_addr_i)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(beat_o) &&
         ((interleave_i != $past(interleave_i)) || $stable(addr_o)));

   assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

   assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

   assert_xor_invariant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && interleave_i) |=> !interleave_i || $stable(mix_x));

   assert_lin_invariant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !interleave_i) |=> interleave_i || $stable(mix_l));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .load_i       (load_i),
   .adv_i        (adv_i),
   .interleave_i (interleave_i),
   .start_addr_i (start_addr_i),
   .addr_o       (addr_o),
   .beat_o       (beat_o)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

   localparam int AW = 6;
   localparam int BW = 2;
   localparam int NB = 1 << BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic          adv_i = 1'b0;
   logic          interleave_i = 1'b0;
   logic [AW-1:0] start_addr_i = '0;
   logic [AW-1:0] addr_o;
   logic [BW-1:0] beat_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (load_i),
      .adv_i        (adv_i),
      .interleave_i (interleave_i),
      .start_addr_i (start_addr_i),
      .addr_o       (addr_o),
      .beat_o       (beat_o)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got=%0d expected=%0d", req, got, exp);
      end
   endtask

   task automatic step(input logic ld, input logic av, input logic [AW-1:0] sa);
      @(negedge clk);
      load_i       = ld;
      adv_i        = av;
      start_addr_i = sa;
      @(posedge clk);
      #1;
   endtask

   function automatic int exp_ofs(input int mode, input int s, input int b);
      if (mode != 0) return s ^ b;
      return (s + b) % NB;
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog got=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int up_pat[2];
      up_pat[0] = 5;
      up_pat[1] = 10;

      // R1: reset state
      start_addr_i = '1;
      load_i = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 addr in reset", int'(addr_o), 0);
      chk("R1 beat in reset", int'(beat_o), 0);
      @(negedge clk);
      load_i = 1'b0;
      rst_n  = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 addr after reset", int'(addr_o), 0);
      chk("R1 beat after reset", int'(beat_o), 0);

      for (int mode = 0; mode < 2; mode++) begin
         interleave_i = logic'(mode);
         for (int s = 0; s < NB; s++) begin
            for (int u = 0; u < 2; u++) begin
               logic [AW-1:0] sa;
               sa = AW'((up_pat[u] << BW) | s);
               step(1'b1, 1'b0, sa);
               chk("R2 load addr", int'(addr_o), int'(sa));
               chk("R2 load beat", int'(beat_o), 0);
               for (int k = 1; k <= NB + 1; k++) begin
                  // scramble start input to show it is ignored without load
                  step(1'b0, 1'b1, ~sa);
                  chk("R9 beat step", int'(beat_o), k % NB);
                  chk(mode != 0 ? "R4 xor offset" : "R5 linear offset",
                      int'(addr_o[BW-1:0]), exp_ofs(mode, s, k % NB));
                  chk("R8 upper fixed", int'(addr_o[AW-1:BW]), up_pat[u]);
                  if (k == NB) begin
                     chk("R7 wrap offset", int'(addr_o[BW-1:0]), s);
                  end
                  if (k == 2) begin
                     step(1'b0, 1'b0, ~sa);
                     chk("R6 hold beat", int'(beat_o), 2);
                     chk("R6 hold addr", int'(addr_o),
                         (up_pat[u] << BW) | exp_ofs(mode, s, 2));
                  end
               end
            end
         end
      end

      // R3: load and advance on the same edge, after a partial burst
      interleave_i = 1'b1;
      step(1'b1, 1'b0, 6'h1D);
      step(1'b0, 1'b1, 6'h00);
      step(1'b1, 1'b1, 6'h26);
      chk("R3 load+adv beat", int'(beat_o), 0);
      chk("R3 load+adv addr", int'(addr_o), 'h26);
      step(1'b0, 1'b1, 6'h00);
      chk("R3 first adv after load", int'(addr_o), 'h27);

      // R5: linear reload mid-burst with start 11
      interleave_i = 1'b0;
      step(1'b1, 1'b1, 6'h33);
      step(1'b0, 1'b1, 6'h00);
      chk("R5 linear 11->00", int'(addr_o), 'h30);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule